// File: doc/BRIEF.md
# GPIO Port with Edge Interrupts

This block is a general-purpose I/O port of up to sixteen pins. Software controls it over a small register bus that has a write strobe, an address, write data and a combinational read path. Through the registers it sets each pin's function, direction, output latch, trigger edge, peripheral routing and interrupt mask. Every pin input passes through a two-flop synchronizer and an edge detector. When the selected edge appears, the pin's sticky pending flag is set. Software clears a flag by writing 1 to its bit in the event register. The interrupt output is the OR of every pending flag that has its mask bit set.

Two pins are set aside for modem control: a clear-to-send line and a carrier-detect line, both active low. Either one can be routed to an internal serial-controller input. A routed pin still takes part in edge detection and still raises interrupts, so the serial controller uses the line for flow control while software sees every transition. An unrouted line feeds its inactive (high) level to the controller. Outputs are push-pull only; no open-drain mode exists.

Register addresses: 0 pin function, 1 direction, 2 data, 3 edge select, 4 routing, 5 interrupt mask, 6 event. A read of address 7 returns 0.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0, `pin_oe` is all zeros, and both `ser_cts_n` and `ser_cd_n` are 1. While all pins are low, a read of the data address also returns 0.
- R2: A read of address 2 (data) returns the synchronized pin level, whatever the direction and function of the pin. A change on `pin_in` becomes visible there after exactly two rising clock edges.
- R3: When a pin's edge-select bit is 0, either transition on the pin sets its pending bit in the event register (address 6). The bit becomes visible after exactly three rising clock edges.
- R4: When a pin's edge-select bit (address 3) is 1, only a high-to-low transition sets its pending bit. A low-to-high transition leaves it clear.
- R5: Pending bits are sticky. A write to address 6 clears exactly the bits written as 1, and bits written as 0 keep their value.
- R6: When a clear write and a new qualifying edge reach the same pending bit at the same clock edge, the bit stays set.
- R7: `irq` is 1 exactly when some pending bit has its mask bit (address 5) set. It changes at the clock edge that updates the mask or the pending bit.
- R8: `pin_out` always carries the data latch written to address 2. `pin_oe[i]` is 1 only when direction bit i (address 1) is 1 and function bit i (address 0) is 0.
- R9: `ser_cts_n` (pin CTS_PIN) and `ser_cd_n` (pin CD_PIN) carry the synchronized pin level only while that pin has function bit 0, direction bit 0 and routing bit 1 (address 4). Otherwise they are 1.
- R10: A routed modem pin keeps setting its pending bit on qualifying edges, just as an unrouted pin does.
- R11: The routing register stores only bits CTS_PIN and CD_PIN. All other bits read back 0.
- R12: The function, direction, edge-select and mask registers read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | PINS | Write data |
| bus_rdata | output | PINS | Read data for `bus_addr` (combinational) |
| pin_in | input | PINS | Pin input levels |
| pin_out | output | PINS | Pin output levels (data latch) |
| pin_oe | output | PINS | Pin output enables |
| ser_cts_n | output | 1 | Clear-to-send line to the serial controller, active low |
| ser_cd_n | output | 1 | Carrier-detect line to the serial controller, active low |
| irq | output | 1 | Interrupt request |

## Verification
Timing is counted from a pin change: the level appears on the data read and on the routed serial lines after two rising edges, and the pending bit appears after three. Register writes, mask changes and event clears show up right after the edge that takes the write, because `irq`, the output enables and the read path are combinational from the registers. The bench changes inputs on falling edges and samples on falling edges after exactly the number of rising edges listed above. Where timing matters, it also samples one edge earlier to show the result does not arrive early. The set-versus-clear test issues its clear in the cycle before the edge that sets the flag.

// File: rtl/gpio_edge_pkg.sv
`timescale 1ns/1ps
package gpio_edge_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_FUNC  = 3'd0,
        REG_DIR   = 3'd1,
        REG_DATA  = 3'd2,
        REG_EDGE  = 3'd3,
        REG_ROUTE = 3'd4,
        REG_MASK  = 3'd5,
        REG_EVENT = 3'd6
    } reg_addr_e;

endpackage

// File: rtl/gpio_pin_sampler.sv
`timescale 1ns/1ps
module gpio_pin_sampler #(
    parameter int PINS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] pin_in,
    output logic [PINS-1:0] lvl,
    output logic [PINS-1:0] prev,
    output logic [PINS-1:0] rise,
    output logic [PINS-1:0] fall
);

    typedef struct packed {
        logic [PINS-1:0] meta;
        logic [PINS-1:0] lvl;
        logic [PINS-1:0] prev;
    } smp_t;

    smp_t smp_d, smp_q;

    always_comb begin
        smp_d      = smp_q;
        smp_d.meta = pin_in;
        smp_d.lvl  = smp_q.meta;
        smp_d.prev = smp_q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) smp_q <= '0;
        else        smp_q <= smp_d;
    end

    assign lvl  = smp_q.lvl;
    assign prev = smp_q.prev;

    for (genvar i = 0; i < PINS; i++) begin : g_edge
        assign rise[i] =  smp_q.lvl[i] & ~smp_q.prev[i];
        assign fall[i] = ~smp_q.lvl[i] &  smp_q.prev[i];
    end

endmodule

// File: rtl/gpio_cfg_regs.sv
`timescale 1ns/1ps
module gpio_cfg_regs
    import gpio_edge_pkg::*;
#(
    parameter int PINS    = 16,
    parameter int CTS_PIN = 10,
    parameter int CD_PIN  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   func_sel,
    output logic [PINS-1:0]   dir,
    output logic [PINS-1:0]   out_latch,
    output logic [PINS-1:0]   edge_sel,
    output logic [PINS-1:0]   route_en,
    output logic [PINS-1:0]   irq_mask
);

    localparam logic [PINS-1:0] ROUTE_BITS =
        (PINS'(1) << CTS_PIN) | (PINS'(1) << CD_PIN);

    typedef struct packed {
        logic [PINS-1:0] func_sel;
        logic [PINS-1:0] dir;
        logic [PINS-1:0] out_latch;
        logic [PINS-1:0] edge_sel;
        logic [PINS-1:0] route_en;
        logic [PINS-1:0] irq_mask;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (bus_wr) begin
            case (reg_addr_e'(bus_addr))
                REG_FUNC:  cfg_d.func_sel  = bus_wdata;
                REG_DIR:   cfg_d.dir       = bus_wdata;
                REG_DATA:  cfg_d.out_latch = bus_wdata;
                REG_EDGE:  cfg_d.edge_sel  = bus_wdata;
                REG_ROUTE: cfg_d.route_en  = bus_wdata & ROUTE_BITS;
                REG_MASK:  cfg_d.irq_mask  = bus_wdata;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign func_sel  = cfg_q.func_sel;
    assign dir       = cfg_q.dir;
    assign out_latch = cfg_q.out_latch;
    assign edge_sel  = cfg_q.edge_sel;
    assign route_en  = cfg_q.route_en;
    assign irq_mask  = cfg_q.irq_mask;

endmodule

// File: rtl/gpio_event_ctrl.sv
`timescale 1ns/1ps
module gpio_event_ctrl #(
    parameter int PINS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PINS-1:0] rise,
    input  logic [PINS-1:0] fall,
    input  logic [PINS-1:0] edge_sel,
    input  logic            clr_en,
    input  logic [PINS-1:0] clr_bits,
    input  logic [PINS-1:0] irq_mask,
    output logic [PINS-1:0] pend,
    output logic            irq
);

    typedef struct packed {
        logic [PINS-1:0] pend;
    } ev_t;

    ev_t             ev_d, ev_q;
    logic [PINS-1:0] trig;

    for (genvar i = 0; i < PINS; i++) begin : g_trig
        assign trig[i] = edge_sel[i] ? fall[i] : (rise[i] | fall[i]);
    end

    always_comb begin
        ev_d = ev_q;
        if (clr_en) ev_d.pend = ev_d.pend & ~clr_bits;
        ev_d.pend = ev_d.pend | trig;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ev_q <= '0;
        else        ev_q <= ev_d;
    end

    assign pend = ev_q.pend;
    assign irq  = |(ev_q.pend & irq_mask);

endmodule

// File: rtl/gpio_modem_route.sv
`timescale 1ns/1ps
module gpio_modem_route #(
    parameter int LINES = 2
) (
    input  logic [LINES-1:0] func_sel,
    input  logic [LINES-1:0] dir,
    input  logic [LINES-1:0] route_en,
    input  logic [LINES-1:0] lvl,
    output logic [LINES-1:0] line_n
);

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic routed;
        assign routed    = ~func_sel[i] & ~dir[i] & route_en[i];
        assign line_n[i] = routed ? lvl[i] : 1'b1;
    end

endmodule

// File: rtl/gpio_edge_port.sv
`timescale 1ns/1ps
module gpio_edge_port
    import gpio_edge_pkg::*;
#(
    parameter int PINS    = 16,
    parameter int CTS_PIN = 10,
    parameter int CD_PIN  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    output logic              ser_cts_n,
    output logic              ser_cd_n,
    output logic              irq
);

    localparam int MODEM_LINES = 2;

    logic [PINS-1:0] smp_lvl, smp_prev, smp_rise, smp_fall;
    logic [PINS-1:0] cfg_func, cfg_dir, cfg_latch, cfg_edge, cfg_route, cfg_mask;
    logic [PINS-1:0] ev_pend;
    logic            ev_clr;
    logic [MODEM_LINES-1:0] modem_n;

    gpio_pin_sampler #(.PINS(PINS)) u_sampler (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .lvl    (smp_lvl),
        .prev   (smp_prev),
        .rise   (smp_rise),
        .fall   (smp_fall)
    );

    gpio_cfg_regs #(.PINS(PINS), .CTS_PIN(CTS_PIN), .CD_PIN(CD_PIN)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .func_sel  (cfg_func),
        .dir       (cfg_dir),
        .out_latch (cfg_latch),
        .edge_sel  (cfg_edge),
        .route_en  (cfg_route),
        .irq_mask  (cfg_mask)
    );

    assign ev_clr = bus_wr && (reg_addr_e'(bus_addr) == REG_EVENT);

    gpio_event_ctrl #(.PINS(PINS)) u_event (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise     (smp_rise),
        .fall     (smp_fall),
        .edge_sel (cfg_edge),
        .clr_en   (ev_clr),
        .clr_bits (bus_wdata),
        .irq_mask (cfg_mask),
        .pend     (ev_pend),
        .irq      (irq)
    );

    gpio_modem_route #(.LINES(MODEM_LINES)) u_route (
        .func_sel ({cfg_func[CD_PIN],  cfg_func[CTS_PIN]}),
        .dir      ({cfg_dir[CD_PIN],   cfg_dir[CTS_PIN]}),
        .route_en ({cfg_route[CD_PIN], cfg_route[CTS_PIN]}),
        .lvl      ({smp_lvl[CD_PIN],   smp_lvl[CTS_PIN]}),
        .line_n   (modem_n)
    );

    assign ser_cts_n = modem_n[0];
    assign ser_cd_n  = modem_n[1];

    assign pin_out = cfg_latch;
    assign pin_oe  = cfg_dir & ~cfg_func;

    always_comb begin
        case (reg_addr_e'(bus_addr))
            REG_FUNC:  bus_rdata = cfg_func;
            REG_DIR:   bus_rdata = cfg_dir;
            REG_DATA:  bus_rdata = smp_lvl;
            REG_EDGE:  bus_rdata = cfg_edge;
            REG_ROUTE: bus_rdata = cfg_route;
            REG_MASK:  bus_rdata = cfg_mask;
            REG_EVENT: bus_rdata = ev_pend;
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_edge_port_chk.sv
`timescale 1ns/1ps
module gpio_edge_port_chk
    import gpio_edge_pkg::*;
#(
    parameter int PINS    = 16,
    parameter int CTS_PIN = 10,
    parameter int CD_PIN  = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              irq,
    input logic [PINS-1:0]   pin_oe,
    input logic              ser_cts_n,
    input logic              ser_cd_n,
    input logic [PINS-1:0]   cfg_func,
    input logic [PINS-1:0]   cfg_dir,
    input logic [PINS-1:0]   cfg_edge,
    input logic [PINS-1:0]   cfg_route,
    input logic [PINS-1:0]   cfg_mask,
    input logic [PINS-1:0]   ev_pend,
    input logic [PINS-1:0]   smp_prev
);

    localparam logic [PINS-1:0] MODEM_BITS =
        (PINS'(1) << CTS_PIN) | (PINS'(1) << CD_PIN);

    // R1
    reset_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq && pin_oe == '0 && ser_cts_n && ser_cd_n));

    // R3
    pend_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ev_pend & ~$past(ev_pend) & ~(smp_prev ^ $past(smp_prev))) == '0));

    // R4
    fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ev_pend & ~$past(ev_pend) & $past(cfg_edge) & smp_prev) == '0));

    // R5
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && reg_addr_e'(bus_addr) == REG_EVENT)
        |=> ((ev_pend & $past(ev_pend)) == $past(ev_pend)));

    // R7
    irq_needs_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ev_pend != '0 && cfg_mask != '0));

    // R8
    oe_qualified_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe & cfg_func) == '0) && ((pin_oe & ~cfg_dir) == '0));

    // R9
    cts_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_cts_n |-> (!cfg_func[CTS_PIN] && !cfg_dir[CTS_PIN] && cfg_route[CTS_PIN]));

    // R9
    cd_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_cd_n |-> (!cfg_func[CD_PIN] && !cfg_dir[CD_PIN] && cfg_route[CD_PIN]));

    // R11
    route_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_route & ~MODEM_BITS) == '0);

endmodule

bind gpio_edge_port gpio_edge_port_chk #(
    .PINS(PINS), .CTS_PIN(CTS_PIN), .CD_PIN(CD_PIN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .irq       (irq),
    .pin_oe    (pin_oe),
    .ser_cts_n (ser_cts_n),
    .ser_cd_n  (ser_cd_n),
    .cfg_func  (cfg_func),
    .cfg_dir   (cfg_dir),
    .cfg_edge  (cfg_edge),
    .cfg_route (cfg_route),
    .cfg_mask  (cfg_mask),
    .ev_pend   (ev_pend),
    .smp_prev  (smp_prev)
);

// File: tb/gpio_edge_port_test.sv
`timescale 1ns/1ps
module gpio_edge_port_test;

    localparam int PINS = 16;
    localparam int CTS  = 10;
    localparam int CD   = 11;
    localparam logic [2:0] A_FUNC = 3'd0, A_DIR = 3'd1, A_DATA = 3'd2, A_EDGE = 3'd3,
                           A_ROUTE = 3'd4, A_MASK = 3'd5, A_EVENT = 3'd6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_wr = 1'b0;
    logic [2:0]      bus_addr = 3'd0;
    logic [PINS-1:0] bus_wdata = '0;
    logic [PINS-1:0] bus_rdata;
    logic [PINS-1:0] pins = '0;
    logic [PINS-1:0] pin_out, pin_oe;
    logic            ser_cts_n, ser_cd_n, irq;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    gpio_edge_port #(.PINS(PINS), .CTS_PIN(CTS), .CD_PIN(CD)) uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pins),
        .pin_out(pin_out), .pin_oe(pin_oe), .ser_cts_n(ser_cts_n),
        .ser_cd_n(ser_cd_n), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [PINS-1:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic expect_reg(input string req, input logic [2:0] a, input logic [PINS-1:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic test_reset();
        for (int a = 0; a < 8; a++) expect_reg("R1 register", 3'(a), '0);
        check("R1 irq", irq, 0);
        check("R1 pin_oe", pin_oe, 0);
        check("R1 ser_cts_n", ser_cts_n, 1);
        check("R1 ser_cd_n", ser_cd_n, 1);
    endtask

    task automatic test_regs();
        wr(A_FUNC, 16'h1234); expect_reg("R12 func", A_FUNC, 16'h1234);
        wr(A_DIR,  16'h8001); expect_reg("R12 dir",  A_DIR,  16'h8001);
        wr(A_EDGE, 16'h00F0); expect_reg("R12 edge", A_EDGE, 16'h00F0);
        wr(A_MASK, 16'hC003); expect_reg("R12 mask", A_MASK, 16'hC003);
        wr(A_ROUTE, 16'hFFFF); expect_reg("R11 route bits", A_ROUTE, 16'h0C00);
        wr(A_FUNC, '0); wr(A_DIR, '0); wr(A_EDGE, '0); wr(A_MASK, '0); wr(A_ROUTE, '0);
        expect_reg("R12 event untouched", A_EVENT, '0);
    endtask

    task automatic test_output();
        wr(A_DATA, 16'hA5A5);
        check("R8 pin_out latch", pin_out, 16'hA5A5);
        check("R8 oe all inputs", pin_oe, 16'h0000);
        expect_reg("R2 data reads pins not latch", A_DATA, 16'h0000);
        wr(A_DIR, 16'h00FF);
        check("R8 oe from dir", pin_oe, 16'h00FF);
        wr(A_FUNC, 16'h000F);
        check("R8 oe gated by function", pin_oe, 16'h00F0);
        wr(A_FUNC, '0); wr(A_DIR, '0); wr(A_DATA, '0);
        check("R8 pin_out cleared", pin_out, 16'h0000);
    endtask

    task automatic test_data_read();
        wr(A_DIR, 16'h0008);
        pins[3] = 1'b1;
        step(1); expect_reg("R2 data not early", A_DATA, 16'h0000);
        step(1); expect_reg("R2 data after two edges", A_DATA, 16'h0008);
        pins[3] = 1'b0;
        step(2); expect_reg("R2 data low again", A_DATA, 16'h0000);
        wr(A_DIR, '0);
        step(1);
        wr(A_EVENT, 16'hFFFF);
        expect_reg("R5 cleared after data test", A_EVENT, 16'h0000);
    endtask

    task automatic test_any_edge();
        pins[0] = 1'b1;
        step(2); expect_reg("R3 pending not early", A_EVENT, 16'h0000);
        step(1); expect_reg("R3 rising sets pending", A_EVENT, 16'h0001);
        wr(A_EVENT, 16'h0001);
        pins[0] = 1'b0;
        step(3); expect_reg("R3 falling sets pending", A_EVENT, 16'h0001);
        wr(A_EVENT, 16'h0001);
        pins[7:4] = 4'hF;
        step(3); expect_reg("R3 several pins at once", A_EVENT, 16'h00F0);
        wr(A_EVENT, 16'h00F0);
        pins[7:4] = 4'h0;
        step(3);
        wr(A_EVENT, 16'h00F0);
    endtask

    task automatic test_fall_only();
        wr(A_EDGE, 16'h0002);
        pins[1] = 1'b1;
        step(4); expect_reg("R4 rising ignored", A_EVENT, 16'h0000);
        pins[1] = 1'b0;
        step(2); expect_reg("R4 falling not early", A_EVENT, 16'h0000);
        step(1); expect_reg("R4 falling sets pending", A_EVENT, 16'h0002);
        wr(A_EVENT, 16'h0002);
        wr(A_EDGE, '0);
    endtask

    task automatic test_sticky();
        pins[2] = 1'b1;
        step(8); expect_reg("R5 pending held", A_EVENT, 16'h0004);
        wr(A_EVENT, 16'h0000); expect_reg("R5 zero write keeps", A_EVENT, 16'h0004);
        wr(A_EVENT, 16'hFFFB); expect_reg("R5 other bits keep", A_EVENT, 16'h0004);
        wr(A_EVENT, 16'h0004); expect_reg("R5 one clears", A_EVENT, 16'h0000);
        pins[2] = 1'b0;
        step(3);
        wr(A_EVENT, 16'h0004);
    endtask

    task automatic test_set_wins();
        pins[5] = 1'b1;
        step(3); expect_reg("R6 setup pending", A_EVENT, 16'h0020);
        pins[5] = 1'b0;
        step(2);
        wr(A_EVENT, 16'h0020);
        expect_reg("R6 edge beats clear", A_EVENT, 16'h0020);
        wr(A_EVENT, 16'h0020);
        expect_reg("R6 later clear works", A_EVENT, 16'h0000);
    endtask

    task automatic test_irq();
        pins[9] = 1'b1;
        step(3);
        check("R7 masked off", irq, 0);
        wr(A_MASK, 16'h0001); check("R7 other mask bit", irq, 0);
        wr(A_MASK, 16'h0200); check("R7 mask enables irq", irq, 1);
        wr(A_EVENT, 16'h0200); check("R7 clear drops irq", irq, 0);
        pins[9] = 1'b0;
        step(2); check("R7 irq not early", irq, 0);
        step(1); check("R7 irq with pending", irq, 1);
        wr(A_EVENT, 16'h0200);
        wr(A_MASK, '0);
        check("R7 idle irq", irq, 0);
    endtask

    task automatic test_route();
        check("R9 unrouted cts inactive", ser_cts_n, 1);
        check("R9 unrouted cd inactive", ser_cd_n, 1);
        wr(A_ROUTE, 16'h0C00);
        check("R9 routed cts low", ser_cts_n, 0);
        check("R9 routed cd low", ser_cd_n, 0);
        pins[CTS] = 1'b1;
        step(1); check("R9 cts not early", ser_cts_n, 0);
        step(1); check("R9 cts follows pin", ser_cts_n, 1);
        step(1); expect_reg("R10 routed rising pending", A_EVENT, 16'h0400);
        wr(A_EVENT, 16'h0400);
        pins[CTS] = 1'b0;
        step(2); check("R9 cts back low", ser_cts_n, 0);
        step(1); expect_reg("R10 routed falling pending", A_EVENT, 16'h0400);
        wr(A_EVENT, 16'h0400);
        wr(A_DIR, 16'h0400); check("R9 output pin forces cts inactive", ser_cts_n, 1);
        wr(A_DIR, '0);       check("R9 cts routed again", ser_cts_n, 0);
        wr(A_FUNC, 16'h0800);
        check("R9 peripheral function forces cd inactive", ser_cd_n, 1);
        check("R9 cts unaffected by cd function", ser_cts_n, 0);
        wr(A_FUNC, '0);
        pins[CD] = 1'b1;
        step(3);
        check("R9 cd follows pin", ser_cd_n, 1);
        expect_reg("R10 cd pending", A_EVENT, 16'h0800);
        wr(A_EVENT, 16'h0800);
        wr(A_ROUTE, '0);
        check("R9 route off", ser_cd_n, 1);
    endtask

    initial begin
        #(20ns * 100000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        test_reset();
        test_regs();
        test_output();
        test_data_read();
        test_any_edge();
        test_fall_only();
        test_sticky();
        test_set_wins();
        test_irq();
        test_route();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule